// File: doc/BRIEF.md
# Pipelined Exception Status Tracker

This block follows the fault status of every instruction in a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Each instruction's slot carries a two-bit status code and its PC. Fetch classifies the instruction as clean, a halt, a bad fetch address or an illegal opcode. Decode and execute pass the code along unchanged. The memory stage may replace a clean code with a data-address fault. A fault is acted on only when its instruction reaches write-back. As a result, faults are reported in program order, and a fault on a cancelled wrong-path instruction never surfaces.

The block also produces the enables that keep younger instructions from changing architectural state. The condition-code update in execute is blocked in the same cycle that the memory stage holds a non-clean instruction. The memory write and the condition-code update are both blocked while write-back holds one. When a fault is raised, a sticky stopped flag is set, fetch is turned into bubbles, and the fault code and PC are held on the outputs until reset. The datapath, the handler call and any stack push are outside this block.

Top module: `pipe_exc_tracker`

## Requirements
- R1: After synchronous reset every stage holds status 0 with PC 0, `stopped` and `exc_raise` are 0, and `cc_allow`, `mem_wr_allow` and `fetch_run` are 1.
- R2: The fetch status code is 2 (bad address) when `f_addr_bad` is set, otherwise 3 (illegal) when `f_op_bad` is set, otherwise 1 (halt) when `f_halt` is set, otherwise 0 (OK).
- R3: An instruction taken in at one rising edge appears on `wb_status`/`wb_pc` after three further edges, with its code unchanged by decode and execute.
- R4: When `m_addr_bad` is high and the memory-stage code is 0, that instruction enters write-back with code 2. A non-zero memory-stage code passes unchanged whatever `m_addr_bad` is.
- R5: `kill_d` loads decode, and `kill_e` loads execute, with code 0 and PC 0 at the next edge. A cancelled fault is never raised.
- R6: `exc_raise` is high in a cycle where `wb_status` is non-zero and `stopped` is low. At that edge `stopped` becomes 1 and `exc_code`/`exc_pc` capture the write-back code and PC. `stopped` stays 1 until reset.
- R7: `cc_allow` is low whenever the memory stage's code after the R4 merge is non-zero, or `wb_status` is non-zero, or `stopped` is set.
- R8: `mem_wr_allow` is low whenever `wb_status` is non-zero or `stopped` is set, and high otherwise.
- R9: `fetch_run` is low whenever `wb_status` is non-zero or `stopped` is set. While it is low, decode is loaded with code 0 and PC 0.
- R10: Once stopped, later non-zero codes at write-back neither pulse `exc_raise` nor change `exc_code`/`exc_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_pc | input | 16 | PC of the instruction being fetched |
| f_addr_bad | input | 1 | Fetch address invalid |
| f_op_bad | input | 1 | Fetched opcode invalid |
| f_halt | input | 1 | Fetched instruction is a halt |
| kill_d | input | 1 | Cancel the instruction entering decode |
| kill_e | input | 1 | Cancel the instruction entering execute |
| m_addr_bad | input | 1 | Data address of the memory-stage instruction invalid |
| wb_status | output | 2 | Status code in write-back |
| wb_pc | output | 16 | PC in write-back |
| exc_raise | output | 1 | Fault raised this cycle |
| stopped | output | 1 | Sticky stop flag |
| exc_code | output | 2 | Captured fault code |
| exc_pc | output | 16 | Captured fault PC |
| cc_allow | output | 1 | Condition-code update enable for execute |
| mem_wr_allow | output | 1 | Memory write enable for the memory stage |
| fetch_run | output | 1 | Fetch may proceed |

## Verification
The assertions check on every cycle that cancelled or blocked slots become clean bubbles, that a merged memory fault drops the condition-code enable, that write-back faults drop the memory write enable, and that the captured code stays frozen once stopped. The bench's scenarios show what no single-cycle property can: that a wrong-path illegal opcode cancelled by a kill never reaches write-back, that the earlier fetch fault wins over a later data fault on the same instruction, and that fetch priority picks bad address over illegal over halt.

// File: rtl/pxt_pkg.sv
package pxt_pkg;

    parameter int PC_W     = 16;
    parameter int N_STAGES = 4;

    localparam int IDX_D = 0;
    localparam int IDX_E = 1;
    localparam int IDX_M = 2;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        ST_OK  = 2'd0,
        ST_HLT = 2'd1,
        ST_ADR = 2'd2,
        ST_INS = 2'd3
    } stat_e;

    typedef struct packed {
        stat_e            st;
        logic [PC_W-1:0]  pc;
    } slot_t;

    localparam slot_t BUBBLE = '{st: ST_OK, pc: '0};

    function automatic stat_e classify(input logic adr_bad,
                                       input logic op_bad,
                                       input logic halt);
        if (adr_bad)     return ST_ADR;
        else if (op_bad) return ST_INS;
        else if (halt)   return ST_HLT;
        else             return ST_OK;
    endfunction

endpackage

// File: rtl/pxt_fetch_tag.sv
module pxt_fetch_tag
    import pxt_pkg::*;
(
    input  logic [PC_W-1:0] pc_i,
    input  logic            adr_bad_i,
    input  logic            op_bad_i,
    input  logic            halt_i,
    output slot_t           slot_o
);
    always_comb begin
        slot_o.st = classify(adr_bad_i, op_bad_i, halt_i);
        slot_o.pc = pc_i;
    end
endmodule

// File: rtl/pxt_stage_reg.sv
module pxt_stage_reg
    import pxt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  kill_i,
    input  slot_t d_i,
    output slot_t q_o
);
    always_ff @(posedge clk) begin
        if (rst || kill_i) q_o <= BUBBLE;
        else               q_o <= d_i;
    end

    AST_BUBBLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        kill_i |=> (q_o.st == ST_OK && q_o.pc == '0)); // R5
endmodule

// File: rtl/pxt_mem_merge.sv
module pxt_mem_merge
    import pxt_pkg::*;
(
    input  slot_t m_i,
    input  logic  data_bad_i,
    output slot_t m_o,
    output logic  m_fault_o
);
    always_comb begin
        m_o = m_i;
        if (m_i.st == ST_OK && data_bad_i) m_o.st = ST_ADR;
        m_fault_o = (m_o.st != ST_OK);
    end
endmodule

// File: rtl/pxt_ctl.sv
module pxt_ctl
    import pxt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  slot_t           wb_i,
    input  logic            m_fault_i,
    output logic            raise_o,
    output logic            stopped_o,
    output stat_e           code_o,
    output logic [PC_W-1:0] pc_o,
    output logic            cc_allow_o,
    output logic            mem_allow_o,
    output logic            run_o
);
    logic wb_fault;

    always_comb begin
        wb_fault    = (wb_i.st != ST_OK);
        raise_o     = wb_fault && !stopped_o;
        run_o       = !stopped_o && !wb_fault;
        mem_allow_o = run_o;
        cc_allow_o  = run_o && !m_fault_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stopped_o <= 1'b0;
            code_o    <= ST_OK;
            pc_o      <= '0;
        end else if (raise_o) begin
            stopped_o <= 1'b1;
            code_o    <= wb_i.st;
            pc_o      <= wb_i.pc;
        end
    end

    AST_LATCH_FAULT: assert property (@(posedge clk) disable iff (rst)
        raise_o |=> (stopped_o && code_o == $past(wb_i.st) && pc_o == $past(wb_i.pc))); // R6
    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
        stopped_o |=> stopped_o); // R6
    AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
        stopped_o |=> ($stable(code_o) && $stable(pc_o) && !raise_o)); // R10
endmodule

// File: rtl/pipe_exc_tracker.sv
module pipe_exc_tracker
    import pxt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] f_pc,
    input  logic            f_addr_bad,
    input  logic            f_op_bad,
    input  logic            f_halt,
    input  logic            kill_d,
    input  logic            kill_e,
    input  logic            m_addr_bad,
    output logic [1:0]      wb_status,
    output logic [PC_W-1:0] wb_pc,
    output logic            exc_raise,
    output logic            stopped,
    output logic [1:0]      exc_code,
    output logic [PC_W-1:0] exc_pc,
    output logic            cc_allow,
    output logic            mem_wr_allow,
    output logic            fetch_run
);
    slot_t               fetched;
    slot_t               m_merged;
    logic                m_fault;
    slot_t               src [N_STAGES];
    slot_t               stg [N_STAGES];
    logic [N_STAGES-1:0] kill_v;
    stat_e               code_q;

    pxt_fetch_tag u_ftag (
        .pc_i      (f_pc),
        .adr_bad_i (f_addr_bad),
        .op_bad_i  (f_op_bad),
        .halt_i    (f_halt),
        .slot_o    (fetched)
    );

    pxt_mem_merge u_merge (
        .m_i        (stg[IDX_M]),
        .data_bad_i (m_addr_bad),
        .m_o        (m_merged),
        .m_fault_o  (m_fault)
    );

    always_comb begin
        src[IDX_D] = fetched;
        src[IDX_E] = stg[IDX_D];
        src[IDX_M] = stg[IDX_E];
        src[IDX_W] = m_merged;
        kill_v         = '0;
        kill_v[IDX_D]  = kill_d || !fetch_run;
        kill_v[IDX_E]  = kill_e;
    end

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        pxt_stage_reg u_reg (
            .clk    (clk),
            .rst    (rst),
            .kill_i (kill_v[i]),
            .d_i    (src[i]),
            .q_o    (stg[i])
        );
    end

    pxt_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .wb_i        (stg[IDX_W]),
        .m_fault_i   (m_fault),
        .raise_o     (exc_raise),
        .stopped_o   (stopped),
        .code_o      (code_q),
        .pc_o        (exc_pc),
        .cc_allow_o  (cc_allow),
        .mem_allow_o (mem_wr_allow),
        .run_o       (fetch_run)
    );

    assign exc_code  = code_q;
    assign wb_status = stg[IDX_W].st;
    assign wb_pc     = stg[IDX_W].pc;

    AST_MEM_KEEP: assert property (@(posedge clk) disable iff (rst)
        (stg[IDX_M].st != ST_OK) |-> (m_merged.st == stg[IDX_M].st)); // R4
    AST_CC_BLOCK: assert property (@(posedge clk) disable iff (rst)
        m_fault |-> !cc_allow); // R7
    AST_MEM_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (wb_status != 2'd0) |-> !mem_wr_allow); // R8
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fetch_run |=> (stg[IDX_D].st == ST_OK)); // R9
endmodule

// File: tb/pipe_exc_tracker_tb.sv
module pipe_exc_tracker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] f_pc = '0;
    logic        f_addr_bad = 1'b0, f_op_bad = 1'b0, f_halt = 1'b0;
    logic        kill_d = 1'b0, kill_e = 1'b0, m_addr_bad = 1'b0;
    logic [1:0]  wb_status, exc_code;
    logic [15:0] wb_pc, exc_pc;
    logic        exc_raise, stopped, cc_allow, mem_wr_allow, fetch_run;

    always #10 clk = ~clk;

    pipe_exc_tracker u_dut (
        .clk(clk), .rst(rst), .f_pc(f_pc), .f_addr_bad(f_addr_bad),
        .f_op_bad(f_op_bad), .f_halt(f_halt), .kill_d(kill_d),
        .kill_e(kill_e), .m_addr_bad(m_addr_bad), .wb_status(wb_status),
        .wb_pc(wb_pc), .exc_raise(exc_raise), .stopped(stopped),
        .exc_code(exc_code), .exc_pc(exc_pc), .cc_allow(cc_allow),
        .mem_wr_allow(mem_wr_allow), .fetch_run(fetch_run)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model: index 0 decode .. 3 write-back
    int ms [4];
    int mp [4];
    int m_stop, m_code, m_epc;

    task automatic chk(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin ms[i] = 0; mp[i] = 0; end
        m_stop = 0; m_code = 0; m_epc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; f_pc = '0; f_addr_bad = 0; f_op_bad = 0; f_halt = 0;
        kill_d = 0; kill_e = 0; m_addr_bad = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        #2;
        chk(wb_status, 0, "R1 wb_status");
        chk(stopped, 0, "R1 stopped");
        chk(exc_raise, 0, "R1 exc_raise");
        chk(cc_allow, 1, "R1 cc_allow");
        chk(mem_wr_allow, 1, "R1 mem_wr_allow");
        chk(fetch_run, 1, "R1 fetch_run");
    endtask

    task automatic cycle(int pc, bit ab, bit ob, bit hl, bit kd, bit ke, bit mb);
        int wbf, mm, run, fs;
        int ns [4];
        int np [4];
        @(negedge clk);
        f_pc = pc[15:0]; f_addr_bad = ab; f_op_bad = ob; f_halt = hl;
        kill_d = kd; kill_e = ke; m_addr_bad = mb;
        #2;
        wbf = (ms[3] != 0);
        mm  = (ms[2] == 0 && mb) ? 2 : ms[2];
        run = (!m_stop && !wbf);
        fs  = ab ? 2 : (ob ? 3 : (hl ? 1 : 0));
        chk(wb_status, ms[3], "R3 wb_status");
        chk(wb_pc, mp[3], "R3 wb_pc");
        chk(exc_raise, wbf && !m_stop, "R6 exc_raise");
        chk(stopped, m_stop, "R6 stopped");
        chk(exc_code, m_code, "R10 exc_code");
        chk(exc_pc, m_epc, "R10 exc_pc");
        chk(cc_allow, run && mm == 0, "R7 cc_allow");
        chk(mem_wr_allow, run, "R8 mem_wr_allow");
        chk(fetch_run, run, "R9 fetch_run");
        @(posedge clk);
        #1;
        if (wbf && !m_stop) begin m_stop = 1; m_code = ms[3]; m_epc = mp[3]; end
        ns[3] = mm;    np[3] = mp[2];
        ns[2] = ms[1]; np[2] = mp[1];
        if (ke) begin ns[1] = 0; np[1] = 0; end
        else    begin ns[1] = ms[0]; np[1] = mp[0]; end
        if (kd || !run) begin ns[0] = 0; np[0] = 0; end
        else            begin ns[0] = fs; np[0] = pc & 16'hFFFF; end
        for (int i = 0; i < 4; i++) begin ms[i] = ns[i]; mp[i] = np[i]; end
    endtask

    task automatic clean(int pc);
        cycle(pc, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        do_reset();

        // clean stream
        for (int k = 0; k < 6; k++) clean(16'h10 + k);
        chk(stopped, 0, "R3 clean stream no stop");

        // illegal opcode reaches write-back
        cycle(16'h20, 0, 1, 0, 0, 0, 0);
        clean(16'h21); clean(16'h22); clean(16'h23);
        chk(wb_status, 3, "R2 illegal code");
        chk(wb_pc, 16'h20, "R3 wb_pc latency");
        chk(exc_raise, 1, "R6 raise at write-back");
        chk(mem_wr_allow, 0, "R8 blocked by write-back fault");
        clean(16'h24);
        chk(stopped, 1, "R6 stopped set");
        chk(exc_code, 3, "R6 captured code");
        chk(exc_pc, 16'h20, "R6 captured pc");
        chk(fetch_run, 0, "R9 fetch halted");
        cycle(16'h25, 1, 0, 0, 0, 0, 1);
        for (int k = 0; k < 4; k++) cycle(16'h26 + k, 1, 1, 1, 0, 0, 1);
        chk(exc_code, 3, "R10 code frozen");
        chk(exc_raise, 0, "R10 no second raise");

        // priority: bad address over illegal over halt
        do_reset();
        cycle(16'h30, 1, 1, 1, 0, 0, 0);
        clean(16'h31); clean(16'h32); clean(16'h33);
        chk(wb_status, 2, "R2 bad address wins");
        do_reset();
        cycle(16'h34, 0, 1, 1, 0, 0, 0);
        clean(16'h35); clean(16'h36); clean(16'h37);
        chk(wb_status, 3, "R2 illegal over halt");
        do_reset();
        cycle(16'h38, 0, 0, 1, 0, 0, 0);
        clean(16'h39); clean(16'h3A); clean(16'h3B);
        chk(wb_status, 1, "R2 halt code");

        // wrong-path faults cancelled
        do_reset();
        cycle(16'h40, 0, 1, 0, 0, 0, 0);
        cycle(16'h41, 1, 0, 0, 1, 1, 0);
        for (int k = 0; k < 6; k++) clean(16'h50 + k);
        chk(stopped, 0, "R5 cancelled fault not raised");
        chk(exc_code, 0, "R5 no code captured");

        // data address fault at memory
        do_reset();
        clean(16'h60); clean(16'h61); clean(16'h62);
        cycle(16'h63, 0, 0, 0, 0, 0, 1);
        chk(wb_status, 2, "R4 data fault merged");
        chk(wb_pc, 16'h60, "R4 faulting pc");
        chk(cc_allow, 0, "R7 cc blocked by write-back fault");
        clean(16'h64);
        chk(exc_code, 2, "R6 data fault captured");

        // earlier fault kept over data fault
        do_reset();
        cycle(16'h70, 0, 0, 1, 0, 0, 0);
        clean(16'h71); clean(16'h72);
        cycle(16'h73, 0, 0, 0, 0, 0, 1);
        chk(wb_status, 1, "R4 earlier code kept");
        clean(16'h74); clean(16'h75);
        chk(exc_pc, 16'h70, "R6 halt pc captured");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule